// File: doc/BRIEF.md
# Serial Boot-Mode Bit Loader

This block fills a wide parallel mode register from a slow serial stream once the board reports that power is good. A serial EEPROM or a few gates of glue logic supply the configuration. The block divides the master clock down to a slow serial clock, drives that clock out to the source, and takes in one mode bit per serial clock period. When the whole register is filled it raises a done flag. The fields of the register are decoded elsewhere.

The serial clock is free-running from reset. It keeps toggling after the load, but the loader then ignores the data input. Power-good passes through a two-flop synchronizer before it can start a load. A loss of power-good in the middle of a load, or after it, drops the bit position and the done flag. The next assertion of power-good then reloads from the first bit.

Top module: `boot_mode_loader`

## Requirements
- R1: `ser_clk_o` is the master clock divided by `DIV` (default 256). Each period has `DIV/2` master cycles high, and the first rising edge comes `DIV/2` master cycles after reset is released. The clock keeps running whatever power-good does.
- R2: While the synchronized power-good is low, no bit is captured and `mode_o` holds its value.
- R3: Each capture takes the value on `ser_data_i` at the master clock edge on which `ser_clk_o` goes high. A full load captures exactly `MODE_BITS` (default 256) bits, one per serial clock period.
- R4: The first captured bit lands in `mode_o[0]` and the k-th bit after it in `mode_o[k]`. A capture changes at most one bit of `mode_o`.
- R5: After a load completes, `ser_clk_o` keeps toggling and `mode_o` no longer follows `ser_data_i`.
- R6: `done_o` rises one master cycle after the edge that captures the last bit. It then stays high for as long as power-good stays high.
- R7: When power-good falls, `done_o` and the bit position clear within three master cycles. `mode_o` keeps its contents, and the next power-good assertion starts a new load at bit 0.
- R8: Reset leaves `ser_clk_o` low, `done_o` low and `mode_o` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Power-good, asynchronous to `clk_i` |
| ser_data_i | input | 1 | Serial mode bit from the external source |
| ser_clk_o | output | 1 | Divided serial clock driven to the source |
| mode_o | output | MODE_BITS | Captured mode register |
| done_o | output | 1 | All mode bits captured |

## Verification
The checker relies on two things. Power-good goes through exactly two synchronizer stages, and `ser_data_i` is meaningful only at rising edges of `ser_clk_o`. The power-good hold property looks back three master cycles on the raw input for that reason.

The stimulus changes the serial data only just after `ser_clk_o` falls, so the value is stable for half a period around every sample point. Power-good is switched only during the low half of the serial clock, far enough ahead of the next rising edge that the first sample after an assertion is always bit 0.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
  localparam int unsigned MODE_BITS_DEF = 256;
  localparam int unsigned DIV_DEF       = 256;
  localparam int unsigned SYNC_STAGES   = 2;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_SHIFT,
    LD_LAST,
    LD_DONE
  } load_state_e;
endpackage

// File: rtl/bml_sync.sv
module bml_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[g] <= 1'b0;
          else         stage_q[g] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[g] <= 1'b0;
          else         stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bml_clk_div.sv
module bml_clk_div #(
  parameter int unsigned DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ser_clk_o,
  output logic tick_o
);
  localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int unsigned HALF = DIV / 2;
  localparam logic [CW-1:0] LAST_C    = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF_C    = CW'(HALF);
  localparam logic [CW-1:0] HALF_M1_C = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          ser_clk_q;

  always_comb begin
    cnt_nxt = (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      ser_clk_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_nxt;
      ser_clk_q <= (cnt_nxt >= HALF_C);
    end
  end

  // sample strobe aligned with the rising edge of ser_clk_o
  assign tick_o    = (cnt_q == HALF_M1_C);
  assign ser_clk_o = ser_clk_q;
endmodule

// File: rtl/bml_capture.sv
module bml_capture
  import boot_mode_pkg::*;
#(
  parameter int unsigned MODE_BITS = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pg_i,
  input  logic                 tick_i,
  input  logic                 data_i,
  output logic [MODE_BITS-1:0] mode_o,
  output logic                 done_o
);
  localparam int unsigned BW = (MODE_BITS > 2) ? $clog2(MODE_BITS) : 1;
  localparam logic [BW-1:0] LAST_IDX = BW'(MODE_BITS - 1);

  load_state_e          state_q;
  logic [BW-1:0]        idx_q;
  logic [MODE_BITS-1:0] mode_q;
  logic                 take;

  assign take = pg_i && (state_q == LD_SHIFT) && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LD_IDLE;
      idx_q   <= '0;
    end else if (!pg_i) begin
      state_q <= LD_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        LD_IDLE:  state_q <= LD_SHIFT;
        LD_SHIFT: if (tick_i) begin
          if (idx_q == LAST_IDX) state_q <= LD_LAST;
          else                   idx_q   <= idx_q + 1'b1;
        end
        LD_LAST:  state_q <= LD_DONE;
        LD_DONE:  state_q <= LD_DONE;
        default:  state_q <= LD_IDLE;
      endcase
    end
  end

  // indexed write: one bit per capture, untouched bits keep their value
  generate
    for (genvar b = 0; b < MODE_BITS; b++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         mode_q[b] <= 1'b0;
        else if (take && idx_q == BW'(b))    mode_q[b] <= data_i;
      end
    end
  endgenerate

  assign mode_o = mode_q;
  assign done_o = (state_q == LD_DONE);
endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
  import boot_mode_pkg::*;
#(
  parameter int unsigned MODE_BITS = MODE_BITS_DEF,
  parameter int unsigned DIV       = DIV_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_good_i,
  input  logic                 ser_data_i,
  output logic                 ser_clk_o,
  output logic [MODE_BITS-1:0] mode_o,
  output logic                 done_o
);
  logic pg_sync;
  logic tick;

  bml_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwr_good_i),
    .q_o   (pg_sync)
  );

  bml_clk_div #(.DIV(DIV)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ser_clk_o(ser_clk_o),
    .tick_o   (tick)
  );

  bml_capture #(.MODE_BITS(MODE_BITS)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pg_i  (pg_sync),
    .tick_i(tick),
    .data_i(ser_data_i),
    .mode_o(mode_o),
    .done_o(done_o)
  );
endmodule

// File: rtl/boot_mode_loader_chk.sv
module boot_mode_loader_chk #(
  parameter int unsigned MODE_BITS = 256,
  parameter int unsigned DIV       = 256
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 pwr_good_i,
  input logic                 ser_clk_o,
  input logic [MODE_BITS-1:0] mode_o,
  input logic                 done_o,
  input logic                 pg_sync
);
  logic        clk_prev_q;
  logic        seen_rise_q;
  int unsigned per_cnt_q;
  logic [2:0]  pg_hist_q;
  logic        rise;

  assign rise = ser_clk_o && !clk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_prev_q  <= 1'b0;
      seen_rise_q <= 1'b0;
      per_cnt_q   <= 0;
      pg_hist_q   <= '0;
    end else begin
      clk_prev_q <= ser_clk_o;
      pg_hist_q  <= {pg_hist_q[1:0], pwr_good_i};
      if (rise) begin
        seen_rise_q <= 1'b1;
        per_cnt_q   <= 1;
      end else begin
        per_cnt_q <= per_cnt_q + 1;
      end
    end
  end

  a_r1_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && seen_rise_q) |-> (per_cnt_q == DIV));

  a_r2_hold_without_pg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_hist_q == 3'b000) |-> $stable(mode_o));

  a_r4_one_bit_per_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_o ^ $past(mode_o)) <= 1);

  a_r5_frozen_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> $stable(mode_o));

  a_r7_done_clears_on_pg_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> !$past(pg_sync));
endmodule

bind boot_mode_loader boot_mode_loader_chk #(
  .MODE_BITS(MODE_BITS),
  .DIV      (DIV)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_good_i(pwr_good_i),
  .ser_clk_o (ser_clk_o),
  .mode_o    (mode_o),
  .done_o    (done_o),
  .pg_sync   (pg_sync)
);

// File: tb/boot_mode_loader_tb_top.sv
`timescale 1ns/1ps
module boot_mode_loader_tb_top;
  localparam int NB  = 256;
  localparam int DIV = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pg = 1'b0;
  logic sd = 1'b0;
  logic          ser_clk;
  logic          done;
  logic [NB-1:0] mode;

  int errs = 0;
  int checks = 0;
  logic [NB-1:0] exp_q[$];
  logic mon_prev = 1'b0;

  always #2.5 clk = ~clk;

  boot_mode_loader #(.MODE_BITS(NB), .DIV(DIV)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .pwr_good_i(pg),
    .ser_data_i(sd),
    .ser_clk_o (ser_clk),
    .mode_o    (mode),
    .done_o    (done)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] gen(input logic [31:0] seed);
    logic [31:0] s = seed;
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      v[i] = s[7];
    end
    return v;
  endfunction

  task automatic wait_rise();
    logic p;
    @(negedge clk); p = ser_clk;
    forever begin
      @(negedge clk);
      if (!p && ser_clk) break;
      p = ser_clk;
    end
  endtask

  task automatic wait_fall();
    logic p;
    @(negedge clk); p = ser_clk;
    forever begin
      @(negedge clk);
      if (p && !ser_clk) break;
      p = ser_clk;
    end
  endtask

  // driver: called just after a falling edge of ser_clk
  task automatic send_bits(input logic [NB-1:0] f, input int n, input bit full);
    if (full) exp_q.push_back(f);
    for (int i = 0; i < n; i++) begin
      sd = f[i];
      wait_rise();
      if (i == n - 1 && full) begin
        chk(done == 1'b0, "R6 done low on capture edge", NB'(done), NB'(0));
        @(negedge clk);
        chk(done == 1'b1, "R6 done one cycle after last bit", NB'(done), NB'(1));
      end else if (i != n - 1) begin
        wait_fall();
      end
    end
  endtask

  // monitor: compare the register against the expected frame when done rises
  always @(negedge clk) begin
    if (done && !mon_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected done", mode, '0);
      end else begin
        logic [NB-1:0] e;
        e = exp_q.pop_front();
        chk(mode == e, "R3 R4 full frame", mode, e);
      end
    end
    mon_prev = done;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [NB-1:0] fa, fb, fc, exp_mix;
    int n, h;
    fa = gen(32'h1234_5678); fa[0] = 1'b1; fa[NB-1] = 1'b1;
    fb = gen(32'hCAFE_0001);
    fc = gen(32'h0BAD_F00D); fc[0] = 1'b0; fc[NB-1] = 1'b1;

    repeat (10) @(negedge clk);
    chk(ser_clk == 1'b0, "R8 reset ser_clk", NB'(ser_clk), NB'(0));
    chk(done == 1'b0, "R8 reset done", NB'(done), NB'(0));
    chk(mode == '0, "R8 reset mode", mode, '0);
    rst_ni = 1'b1;

    // R1: period and high time
    wait_rise();
    n = 0; h = 1;
    begin
      logic p;
      p = ser_clk;
      forever begin
        @(negedge clk); n++;
        if (ser_clk && p && n == h) h++;
        if (!p && ser_clk) break;
        p = ser_clk;
      end
    end
    chk(n == DIV, "R1 period", NB'(n), NB'(DIV));
    chk(h == DIV / 2, "R1 high time", NB'(h), NB'(DIV / 2));

    // R2: no capture without power-good
    sd = 1'b1;
    repeat (3) wait_rise();
    chk(mode == '0, "R2 mode held without pg", mode, '0);
    chk(done == 1'b0, "R2 no done without pg", NB'(done), NB'(0));

    // full load A
    wait_fall();
    pg = 1'b1;
    send_bits(fa, NB, 1'b1);

    // R5: further input ignored, clock still toggles
    for (int k = 0; k < 3; k++) begin
      wait_fall();
      sd = ~fa[k];
      wait_rise();
      chk(mode == fa, "R5 input ignored after done", mode, fa);
    end
    chk(done == 1'b1, "R6 done stays high", NB'(done), NB'(1));

    // R7: power-good loss clears done
    wait_fall();
    pg = 1'b0;
    repeat (5) @(negedge clk);
    chk(done == 1'b0, "R7 done cleared on pg loss", NB'(done), NB'(0));
    chk(mode == fa, "R7 mode kept on pg loss", mode, fa);

    // partial load B, aborted after 40 bits
    pg = 1'b1;
    send_bits(fb, 40, 1'b0);
    wait_fall();
    pg = 1'b0;
    repeat (5) @(negedge clk);
    exp_mix = fa;
    exp_mix[39:0] = fb[39:0];
    chk(done == 1'b0, "R7 no done after aborted load", NB'(done), NB'(0));
    chk(mode == exp_mix, "R4 partial load order", mode, exp_mix);

    // restart: full load C from bit 0
    pg = 1'b1;
    send_bits(fc, NB, 1'b1);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all frames seen", NB'(exp_q.size()), NB'(0));
    chk(mode == fc, "R7 restart reloads from bit 0", mode, fc);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule